// File: doc/BRIEF.md
# Dual-Channel Bus Timer with Interrupt Test Override

This block is a memory-mapped peripheral on an APB bus that holds two independent down-counting timer channels inside one 4 KB address window. Software programs each channel through a small register set: a reload value, a live count, a control word, an interrupt clear, and raw and masked status. Each channel raises its own interrupt line. The block also drives a combined line that is the OR of the two.

For board-level and production testing, a test-mode bit lets software take over both interrupt outputs and drive them from a register. This exercises the interrupt wiring without running a timer. A block of twelve read-only words near the top of the window returns fixed identification bytes that software uses to recognise the peripheral.

The bus side has no wait states and no error response. Reads are combinational during the access phase. Every write is a full 32-bit write.

Top module: `dual_timer_apb`

## Requirements
- R1: PREADY is always high. A register write happens on the clock edge where PSEL, PENABLE and PWRITE are all high. PRDATA is valid while PSEL is high and is zero otherwise. There are no byte strobes, so a write always replaces the whole register.
- R2: Channel registers are selected by PADDR[4:2]: 0 reload value, 1 live count (read-only), 2 control, 3 interrupt clear (write-only, reads 0), 4 raw status in bit 0, 5 masked status in bit 0, 6 background reload. The first channel sits at 0x000–0x018 and the second at 0x020–0x038, chosen by PADDR[5]. A write to one channel never changes the other.
- R3: After reset, each control word reads 0x20, each reload value reads 0, each count reads 0xFFFFFFFF, both test registers read 0, and all interrupt outputs are low.
- R4: The control word has these fields: bit 0 one-shot, bit 1 32-bit width (0 means 16-bit), bits 3:2 prescale (0 divides by 1, 1 by 16, 2 and 3 by 256), bit 5 interrupt enable, bit 6 periodic (0 means free-running), and bit 7 run. Bit 4 and bits 31:8 read as zero.
- R5: Writing the reload register sets both the reload value and the count. Writing the background reload sets only the reload value. While running, each prescaled tick decrements the count within the active width and leaves the upper half untouched in 16-bit mode. The step from 1 to 0 sets raw status. The tick after reaching 0 reloads the count from the reload value in periodic mode, or to all ones of the width in free-running mode. In one-shot mode the count holds at 0.
- R6: Any write to the interrupt clear register clears raw status, except that a raw-status set in the same cycle takes precedence. Masked status equals raw status AND the interrupt-enable bit.
- R7: The test-control register at 0xF00 uses bit 0 as the test-mode enable. The test-output register at 0xF04 holds bit 0 for channel 1 and bit 1 for channel 2. In test mode each channel interrupt output follows its test-output bit; otherwise it follows that channel's masked status.
- R8: The combined interrupt is the OR of the two channel interrupt outputs, taken after the test-mode selection.
- R9: The twelve words 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Their upper 24 bits are zero and writes to them are ignored.
- R10: Undefined offsets read zero and ignore writes. These are 0x01C, 0x03C, 0x040–0xEFC and 0xF08–0xFCC. Unused bits of the test registers also read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released inside |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| irq_ch | output | 2 | Per-channel interrupt outputs after test selection |
| irq_any | output | 1 | OR of the channel interrupt outputs |

## Verification
The counting path is driven with directed patterns:
- A one-shot 32-bit countdown shows that the count holds at zero after expiry.
- A periodic 16-bit run shows that the upper half of the count survives.
- A free-running 16-bit wrap is stopped on an exact cycle to pin the reload to all ones.
- Runs at divide-by-16 and divide-by-256 separate the prescaler settings from one another.

Interrupt routing is checked with raw status set but the enable clear, and again with test mode forcing the lines against live status. This tells masking apart from override.

A seeded random mix of test-register writes, identification reads, and reads and writes at undefined offsets checks the output selection against a bench model. It also confirms that stray writes leave both channels and both test registers intact.

// File: rtl/dt_pkg.sv
package dt_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int CTRL_W   = 8;
  localparam int NARROW_W = 16;

  // word addresses (byte address >> 2)
  localparam logic [ADDR_W-3:0] TEST_CTRL_WORD = 10'h3C0;  // 0xF00
  localparam logic [ADDR_W-3:0] TEST_OUT_WORD  = 10'h3C1;  // 0xF04
  localparam logic [ADDR_W-3:0] ID_FIRST_WORD  = 10'h3F4;  // 0xFD0

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 8'hEF;

  typedef enum logic [2:0] {
    REG_LOAD  = 3'd0,
    REG_COUNT = 3'd1,
    REG_CTRL  = 3'd2,
    REG_ICLR  = 3'd3,
    REG_RAW   = 3'd4,
    REG_MSK   = 3'd5,
    REG_BGL   = 3'd6,
    REG_NONE  = 3'd7
  } ch_reg_e;

  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       irq_en;    // bit 5
    logic       rsvd;      // bit 4
    logic [1:0] presc;     // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  // identification byte for word k counted from 0xFD0
  function automatic logic [7:0] id_byte(input logic [3:0] k);
    logic [7:0] b;
    case (k)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h23;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dt_rst_sync.sv
module dt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dt_tick_gen.sv
module dt_tick_gen #(
  parameter int FAST_LOG = 4,
  parameter int SLOW_LOG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] presc,
  output logic       tick
);

  logic [SLOW_LOG-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  always_comb begin
    cnt_en = run | restart | (|cnt_q);
    cnt_d  = (run && !restart) ? cnt_q + 1'b1 : '0;
  end

  always_comb begin
    case (presc)
      2'd0:    tick = run;
      2'd1:    tick = run & (&cnt_q[FAST_LOG-1:0]);
      default: tick = run & (&cnt_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dt_pkg::*;
#(
  parameter int FAST_LOG = 4,
  parameter int SLOW_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  ch_reg_e           reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_masked
);

  logic [DATA_W-1:0] load_q, load_d, count_q, count_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              raw_q, raw_d;
  logic              load_en, count_en, ctrl_en, raw_en;
  logic              tick, raw_set, load_wr;
  logic [DATA_W-1:0] wmask, cur, src;

  assign load_wr = wr_en && (reg_idx == REG_LOAD);

  dt_tick_gen #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (load_wr),
    .presc   (ctrl_q.presc),
    .tick    (tick)
  );

  assign wmask = ctrl_q.wide ? {DATA_W{1'b1}}
                             : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign cur   = count_q & wmask;

  always_comb begin
    load_d   = load_q;
    count_d  = count_q;
    ctrl_d   = ctrl_q;
    raw_d    = raw_q;
    raw_set  = 1'b0;
    src      = ctrl_q.periodic ? load_q : {DATA_W{1'b1}};
    load_en  = 1'b0;
    count_en = 1'b0;
    ctrl_en  = 1'b0;
    raw_en   = 1'b0;

    if (tick) begin
      if (cur == '0) begin
        if (!ctrl_q.oneshot) begin
          count_d  = (count_q & ~wmask) | (src & wmask);
          count_en = 1'b1;
        end
      end else begin
        count_d  = (count_q & ~wmask) | ((cur - 1'b1) & wmask);
        count_en = 1'b1;
        raw_set  = (cur == {{(DATA_W-1){1'b0}}, 1'b1});
      end
    end

    if (wr_en) begin
      case (reg_idx)
        REG_LOAD: begin
          load_d   = wdata;
          count_d  = wdata;
          load_en  = 1'b1;
          count_en = 1'b1;
        end
        REG_BGL: begin
          load_d  = wdata;
          load_en = 1'b1;
        end
        REG_CTRL: begin
          ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0] & CTRL_MASK);
          ctrl_en = 1'b1;
        end
        REG_ICLR: begin
          raw_d  = 1'b0;
          raw_en = 1'b1;
        end
        default: ;
      endcase
    end

    if (raw_set) begin
      raw_d  = 1'b1;
      raw_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= {DATA_W{1'b1}};
      ctrl_q  <= ctrl_t'(CTRL_RESET);
      raw_q   <= 1'b0;
    end else begin
      if (load_en)  load_q  <= load_d;
      if (count_en) count_q <= count_d;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (raw_en)   raw_q   <= raw_d;
    end
  end

  assign irq_masked = raw_q & ctrl_q.irq_en;

  always_comb begin
    case (reg_idx)
      REG_LOAD, REG_BGL: rdata = load_q;
      REG_COUNT:         rdata = count_q;
      REG_CTRL:          rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      REG_RAW:           rdata = {{(DATA_W-1){1'b0}}, raw_q};
      REG_MSK:           rdata = {{(DATA_W-1){1'b0}}, irq_masked};
      default:           rdata = '0;
    endcase
  end

endmodule

// File: rtl/dt_irq_sel.sv
module dt_irq_sel #(
  parameter int N_CH = 2
) (
  input  logic            test_en,
  input  logic [N_CH-1:0] test_val,
  input  logic [N_CH-1:0] ch_masked,
  output logic [N_CH-1:0] irq,
  output logic            irq_or
);

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign irq[i] = test_en ? test_val[i] : ch_masked[i];
  end

  assign irq_or = |irq;

endmodule

// File: rtl/dual_timer_apb.sv
module dual_timer_apb
  import dt_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int FAST_LOG = 4,
  parameter int SLOW_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [N_CH-1:0]   irq_ch,
  output logic              irq_any
);

  localparam int CH_SEL_W = ADDR_W - 5;
  localparam int WORD_W   = ADDR_W - 2;

  logic                rst_n_sync;
  logic                wr_acc;
  logic [CH_SEL_W-1:0] ch_num;
  logic                ch_hit;
  ch_reg_e             reg_idx;
  logic [WORD_W-1:0]   word;
  logic [N_CH-1:0]     ch_wr, ch_masked;
  logic [DATA_W-1:0]   ch_rdata [N_CH];
  logic                test_en_q, test_en_d, test_en_en;
  logic [N_CH-1:0]     test_val_q, test_val_d;
  logic                test_val_en;
  logic [3:0]          id_k;
  logic [1:0]          unused_byte_lane;

  dt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign pready           = 1'b1;
  assign wr_acc           = psel & penable & pwrite;
  assign word             = paddr[ADDR_W-1:2];
  assign ch_num           = paddr[ADDR_W-1:5];
  assign ch_hit           = ch_num < CH_SEL_W'(N_CH);
  assign reg_idx          = ch_reg_e'(paddr[4:2]);
  assign unused_byte_lane = paddr[1:0];
  assign id_k             = 4'(word - ID_FIRST_WORD);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_wr[i] = wr_acc && ch_hit && (ch_num == CH_SEL_W'(i));

    dt_channel #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n_sync),
      .wr_en      (ch_wr[i]),
      .reg_idx    (reg_idx),
      .wdata      (pwdata),
      .rdata      (ch_rdata[i]),
      .irq_masked (ch_masked[i])
    );
  end

  // test registers
  always_comb begin
    test_en_en  = wr_acc && (word == TEST_CTRL_WORD);
    test_val_en = wr_acc && (word == TEST_OUT_WORD);
    test_en_d   = pwdata[0];
    test_val_d  = pwdata[N_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      test_en_q  <= 1'b0;
      test_val_q <= '0;
    end else begin
      if (test_en_en)  test_en_q  <= test_en_d;
      if (test_val_en) test_val_q <= test_val_d;
    end
  end

  dt_irq_sel #(.N_CH(N_CH)) u_irq (
    .test_en   (test_en_q),
    .test_val  (test_val_q),
    .ch_masked (ch_masked),
    .irq       (irq_ch),
    .irq_or    (irq_any)
  );

  // read multiplexer
  always_comb begin
    prdata = '0;
    if (psel) begin
      if (ch_hit) begin
        for (int i = 0; i < N_CH; i++) begin
          if (ch_num == CH_SEL_W'(i)) prdata = ch_rdata[i];
        end
      end else if (word == TEST_CTRL_WORD) begin
        prdata = {{(DATA_W-1){1'b0}}, test_en_q};
      end else if (word == TEST_OUT_WORD) begin
        prdata = {{(DATA_W-N_CH){1'b0}}, test_val_q};
      end else if (word >= ID_FIRST_WORD) begin
        prdata = {{(DATA_W-8){1'b0}}, id_byte(id_k)};
      end
    end
  end

endmodule

// File: rtl/dual_timer_apb_sva.sv
module dual_timer_apb_sva
  import dt_pkg::*;
#(
  parameter int N_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [N_CH-1:0]   irq_ch,
  input logic              irq_any,
  input logic              test_en
);

  logic rd_acc, undef_addr, id_addr;

  assign rd_acc     = psel && penable && !pwrite;
  assign undef_addr = ((paddr < ADDR_W'(N_CH*32)) && (paddr[4:2] == 3'd7)) ||
                      ((paddr >= ADDR_W'(N_CH*32)) && (paddr < 12'hF00)) ||
                      ((paddr >= 12'hF08) && (paddr < 12'hFD0));
  assign id_addr    = paddr >= 12'hFD0;

  // R7: in test mode the lines follow the value written to the test-output register
  p_test_out_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == 12'hF04 && test_en)
      |=> (irq_ch == $past(pwdata[N_CH-1:0])));

  // R8: combined line is high exactly when some channel line is high
  p_any_needs_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_ch != '0));

  p_channel_drives_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ch != '0) |-> irq_any);

  // R10: undefined offsets read zero
  p_undef_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && undef_addr) |-> (prdata == '0));

  // R9: identification words carry only a low byte
  p_id_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && id_addr) |-> (prdata[DATA_W-1:8] == '0));

endmodule

bind dual_timer_apb dual_timer_apb_sva #(.N_CH(N_CH)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .irq_ch  (irq_ch),
  .irq_any (irq_any),
  .test_en (test_en_q)
);

// File: tb/dual_timer_apb_bench.sv
module dual_timer_apb_bench;

  logic        clk, rst_n, psel, penable, pwrite, pready, irq_any;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [1:0]  irq_ch;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dual_timer_apb u_dual_timer_apb (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    check("R1 pready", {31'b0, pready}, 32'd1);
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic irq_chk(input string req, input logic [1:0] exp);
    @(negedge clk);
    #1;
    check(req, {30'b0, irq_ch}, {30'b0, exp});
    check("R8 combined", {31'b0, irq_any}, {31'b0, |exp});
  endtask

  function automatic logic [31:0] id_exp(input int k);
    case (k)
      0: return 32'h04;  4: return 32'h23;  5: return 32'hB8;  6: return 32'h1B;
      8: return 32'h0D;  9: return 32'hF0; 10: return 32'h05; 11: return 32'hB1;
      default: return 32'h00;
    endcase
  endfunction

  function automatic logic [11:0] undef_addr(input int sel);
    case (sel)
      0: return 12'h01C;
      1: return 12'h03C;
      2: return 12'h040 + 12'($urandom_range(0, 751) * 4);
      default: return 12'hF08 + 12'($urandom_range(0, 49) * 4);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        te;
    logic [1:0]  tv;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 reset state
    rd_chk("R3 ctrl1",  12'h008, 32'h20);
    rd_chk("R3 ctrl2",  12'h028, 32'h20);
    rd_chk("R3 load1",  12'h000, 32'h0);
    rd_chk("R3 count2", 12'h024, 32'hFFFF_FFFF);
    rd_chk("R3 tctl",   12'hF00, 32'h0);
    rd_chk("R3 tout",   12'hF04, 32'h0);
    irq_chk("R3 irq", 2'b00);

    // R1/R5 reload and background reload on channel 1
    apb_wr(12'h000, 32'd3);
    rd_chk("R5 load sets count", 12'h004, 32'd3);
    apb_wr(12'h018, 32'd7);
    rd_chk("R5 bg load value", 12'h000, 32'd7);
    rd_chk("R5 bg keeps count", 12'h004, 32'd3);
    rd_chk("R2 ch2 untouched", 12'h020, 32'd0);
    apb_wr(12'h004, 32'h55);
    rd_chk("R2 count read-only", 12'h004, 32'd3);

    // one-shot 32-bit with enable
    apb_wr(12'h008, 32'hA3);
    repeat (10) @(posedge clk);
    rd_chk("R5 oneshot holds 0", 12'h004, 32'd0);
    rd_chk("R5 raw set", 12'h010, 32'd1);
    rd_chk("R6 masked set", 12'h014, 32'd1);
    irq_chk("R6 irq from masked", 2'b01);
    rd_chk("R2 iclr reads 0", 12'h00C, 32'd0);
    apb_wr(12'h00C, 32'h0);
    rd_chk("R6 clear raw", 12'h010, 32'd0);
    irq_chk("R6 irq cleared", 2'b00);

    // raw set but enable off
    apb_wr(12'h000, 32'd2);
    apb_wr(12'h008, 32'h83);
    repeat (10) @(posedge clk);
    rd_chk("R6 raw w/o enable", 12'h010, 32'd1);
    rd_chk("R6 masked off", 12'h014, 32'd0);
    irq_chk("R6 no irq", 2'b00);

    // R7 override against live status
    apb_wr(12'h008, 32'hA3);
    irq_chk("R6 enable restores", 2'b01);
    apb_wr(12'hF00, 32'h1);
    apb_wr(12'hF04, 32'h2);
    irq_chk("R7 test drives 10", 2'b10);
    apb_wr(12'hF04, 32'h0);
    irq_chk("R7 test masks live", 2'b00);
    apb_wr(12'hF00, 32'h0);
    irq_chk("R7 test off", 2'b01);
    apb_wr(12'h00C, 32'h0);

    // periodic 16-bit on channel 2
    apb_wr(12'h020, 32'h1234_0002);
    rd_chk("R5 ch2 load sets count", 12'h024, 32'h1234_0002);
    rd_chk("R2 ch1 load kept", 12'h000, 32'd2);
    apb_wr(12'h028, 32'hE0);
    repeat (20) @(posedge clk);
    rd_chk("R5 periodic raw", 12'h030, 32'd1);
    apb_wr(12'h028, 32'h20);
    apb_rd(12'h024, d);
    check("R5 16b upper kept", {16'b0, d[31:16]}, 32'h1234);
    check("R5 periodic range", {31'b0, d[15:0] <= 16'd2}, 32'd1);
    apb_wr(12'h02C, 32'h0);

    // free-running 16-bit wrap stopped on an exact cycle
    apb_wr(12'h020, 32'hABCD_0001);
    apb_wr(12'h028, 32'hA0);
    apb_wr(12'h028, 32'h20);
    rd_chk("R5 free wrap 16b", 12'h024, 32'hABCD_FFFF);
    rd_chk("R5 free raw", 12'h030, 32'd1);
    apb_wr(12'h02C, 32'h0);

    // R4 control field layout
    apb_wr(12'h028, 32'hFFFF_FFFF);
    rd_chk("R4 ctrl mask", 12'h028, 32'hEF);
    apb_wr(12'h028, 32'h20);
    apb_wr(12'h020, 32'hABCD_0001);
    apb_wr(12'h02C, 32'h0);

    // R4 prescale divide by 16 and 256
    apb_wr(12'h008, 32'h20);
    apb_wr(12'h000, 32'd1000);
    apb_wr(12'h008, 32'h86);
    repeat (160) @(posedge clk);
    apb_wr(12'h008, 32'h22);
    apb_rd(12'h004, d);
    check("R4 div16", {31'b0, d >= 989 && d <= 991}, 32'd1);
    apb_wr(12'h000, 32'd1000);
    apb_wr(12'h008, 32'h8E);
    repeat (600) @(posedge clk);
    apb_wr(12'h008, 32'h20);
    apb_rd(12'h004, d);
    check("R4 div256", {31'b0, d >= 997 && d <= 999}, 32'd1);
    apb_wr(12'h00C, 32'h0);
    apb_wr(12'h02C, 32'h0);
    irq_chk("R6 quiet", 2'b00);

    // R9 all ID words directed
    for (int k = 0; k < 12; k++) rd_chk("R9 id", 12'hFD0 + 12'(k * 4), id_exp(k));
    apb_wr(12'hFE0, 32'hFFFF_FFFF);
    rd_chk("R9 id write ignored", 12'hFE0, 32'h23);

    // seeded random mix
    void'($urandom(32'd20240611));
    te = 1'b0; tv = 2'b00;
    for (int n = 0; n < 250; n++) begin
      int op;
      logic [31:0] r;
      logic [11:0] a;
      op = $urandom_range(0, 3);
      r  = $urandom;
      case (op)
        0: begin
          apb_wr(12'hF00, r);
          te = r[0];
          rd_chk("R7 tctl readback", 12'hF00, {31'b0, te});
        end
        1: begin
          apb_wr(12'hF04, r);
          tv = r[1:0];
          rd_chk("R10 tout unused zero", 12'hF04, {30'b0, tv});
        end
        2: begin
          int k;
          k = $urandom_range(0, 11);
          rd_chk("R9 id random", 12'hFD0 + 12'(k * 4), id_exp(k));
        end
        default: begin
          a = undef_addr($urandom_range(0, 3));
          rd_chk("R10 undef read", a, 32'h0);
          apb_wr(a, r);
          rd_chk("R10 undef write ch1", 12'h000, 32'd1000);
          rd_chk("R10 undef write ch2", 12'h020, 32'hABCD_0001);
          rd_chk("R10 undef write tctl", 12'hF00, {31'b0, te});
          rd_chk("R10 undef write tout", 12'hF04, {30'b0, tv});
        end
      endcase
      irq_chk("R7 random select", te ? tv : 2'b00);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule